// File: doc/BRIEF.md
# Chained descriptor DMA sequencer

This block is the control engine of one DMA channel. Software places a linked list of buffer descriptors in memory and issues a start command with the address of the first descriptor, a transfer unit size and signed source and destination steps. The engine works through the list one descriptor at a time. It copies the descriptor's byte count in units from the source address to the destination address and keeps a running checksum of the data moved. When a descriptor is finished, it writes the results back into that descriptor and follows the next pointer.

Software steers the channel with pulse commands: start, pause, resume, continue and kill. It observes a 3-bit status code, a set of progress outputs and a one-cycle interrupt. A descriptor that software has not yet handed to the engine parks the channel until a continue command arrives. Memory is reached through two single-cycle ports. The read port returns data in the same cycle as the request. A write request is taken at the clock edge.

Each descriptor is eight 32-bit words at byte offsets 0 to 28. Word 0 holds the flags, word 1 the checksum, word 2 the source address, word 3 the destination address, word 4 the last destination address written, word 5 the byte count, word 6 the next-descriptor pointer and word 7 an info word that belongs to software.

States and transitions:
- OFF goes to FETCH on start.
- FETCH reads words 0 to 6 in seven cycles. It goes to PARK if the owned flag is clear, and to XFER after word 6 has been read.
- PARK goes back to FETCH on continue.
- XFER moves one unit per cycle while the initiator request is high and the channel is not paused. It goes to WBACK once the count is reached.
- WBACK makes three writes. It then goes to FETCH for a non-zero next pointer, or to DONE for a zero one.
- Kill sends every active state to KILLED.
- DONE and KILLED go back to FETCH on a new start.

Top module: `dsc_chain_seq`

## Requirements
- R1: After reset the status is 1 (never started), and neither memory port issues a request until a start is accepted.
- R2: While a transfer phase is active and not paused, the status is 3 when `init_req` is high and 2 when it is low. No data moves while `init_req` is low. FETCH, PARK and WBACK also report 2.
- R3: A descriptor is eight words at byte offsets 0 to 28 of its base: flags, checksum, source, destination, last destination, byte count, next pointer and info. The engine never writes the info word at offset 28.
- R4: If flag bit 31 is clear when word 0 is read, the channel parks with status 2 and performs no writes. A continue command re-reads the same descriptor from word 0.
- R5: `unit_size` codes 0, 1 and 2 select 1, 2 and 4 bytes, and code 3 acts as 2. Each transfer reads one unit at the source and writes it at the destination. The count is in bytes and is rounded up to whole units, and a count of 0 moves nothing.
- R6: After each transfer, the source and destination addresses change by their signed step (4-bit two's complement) times the unit size in bytes.
- R7: The checksum is the 32-bit wrapping sum of the zero-extended units moved. A start clears it. Flag bit 30 clears it before that descriptor's data moves, and otherwise it carries across descriptors.
- R8: When a descriptor finishes, the engine writes the flags with bit 31 cleared to offset 0, the checksum to offset 4, and the last destination address written to offset 16. That address is the initial destination when nothing was moved.
- R9: If flag bit 28 is set, `irq` is high for exactly one cycle, the cycle after the descriptor's last write-back.
- R10: A zero next pointer ends the chain with status 6. Otherwise the engine fetches the descriptor at the next pointer.
- R11: Pause is accepted only in XFER while the count is not yet reached. It shows status 4 and freezes the transfers and the progress outputs until a resume. Pause in any other state is ignored.
- R12: Kill in any active state gives status 5. After that, resume and continue have no effect, and only a new start leaves the state.
- R13: `prog_src` and `prog_dst` show the latest post-increment addresses, `prog_count` shows the bytes moved in the current descriptor, and `prog_desc` shows the current descriptor address.
- R14: A start command while the channel is active (FETCH, PARK, XFER or WBACK) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Start pulse, taken in OFF, DONE or KILLED |
| start_desc | input | AW | Address of the first descriptor |
| unit_size | input | 2 | Transfer unit code: 0, 1 or 2 for 1, 2 or 4 bytes |
| src_step | input | STEPW | Signed source step in units |
| dst_step | input | STEPW | Signed destination step in units |
| cmd_pause | input | 1 | Pause pulse |
| cmd_resume | input | 1 | Resume pulse |
| cmd_continue | input | 1 | Re-fetch a parked descriptor |
| cmd_kill | input | 1 | Kill pulse |
| init_req | input | 1 | Initiator request, permits data transfers |
| rd_en | output | 1 | Read request |
| rd_addr | output | AW | Read byte address |
| rd_size | output | 2 | Read size code |
| rd_data | input | 32 | Read data, little-endian, same cycle |
| wr_en | output | 1 | Write request |
| wr_addr | output | AW | Write byte address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data, little-endian |
| status | output | 3 | Channel status code, 1 to 6 |
| irq | output | 1 | Completion interrupt pulse |
| prog_src | output | AW | Current source address |
| prog_dst | output | AW | Current destination address |
| prog_count | output | CW | Bytes moved in the current descriptor |
| prog_desc | output | AW | Current descriptor address |

## Verification
Random chains of one to three descriptors mix the three unit sizes, steps of -1, 0, +1 and +2, counts from 0 to 24 that are often not whole multiples of the unit, random checksum-restart and interrupt flags, and a toggling initiator request. A memory image computed by a bench model must match the design's memory byte for byte, which separates errors in address stepping, unit width, count rounding, checksum carry and write-back. Directed cases cover the rest:
- A parked descriptor that is later handed over, which exercises park, continue and the info word.
- A long single-byte transfer that is held back by `init_req`, then paused, resumed and killed, which separates status 2, 3, 4 and 5 and checks progress against the step arithmetic.
- A descriptor with a byte count of zero, which isolates the write-back of an untouched destination.

// File: rtl/dsc_seq_pkg.sv
package dsc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_FETCH,
        ST_PARK,
        ST_XFER,
        ST_WBACK,
        ST_DONE,
        ST_KILLED
    } seq_state_e;

    // status codes seen by software
    localparam logic [2:0] STS_NONE  = 3'd1;
    localparam logic [2:0] STS_WAIT  = 3'd2;
    localparam logic [2:0] STS_RUN   = 3'd3;
    localparam logic [2:0] STS_PAUSE = 3'd4;
    localparam logic [2:0] STS_KILL  = 3'd5;
    localparam logic [2:0] STS_DONE  = 3'd6;

    // flag bit positions
    localparam int FL_OWN     = 31;
    localparam int FL_RESTART = 30;
    localparam int FL_IRQ     = 28;

    // descriptor word indices
    localparam logic [2:0] W_FLAGS = 3'd0;
    localparam logic [2:0] W_CSUM  = 3'd1;
    localparam logic [2:0] W_SRC   = 3'd2;
    localparam logic [2:0] W_DST   = 3'd3;
    localparam logic [2:0] W_LAST  = 3'd4;
    localparam logic [2:0] W_COUNT = 3'd5;
    localparam logic [2:0] W_NEXT  = 3'd6;
    localparam logic [2:0] W_INFO  = 3'd7;

endpackage

// File: rtl/dsc_seq_step.sv
// Byte offset for one transfer: the signed step scaled by the unit size.
module dsc_seq_step #(
    parameter int AW    = 16,
    parameter int STEPW = 4
) (
    input  logic [1:0]              unit,
    input  logic signed [STEPW-1:0] step,
    output logic [AW-1:0]           ofs
);
    logic [AW-1:0] ext;

    assign ext = {{(AW-STEPW){step[STEPW-1]}}, step};
    assign ofs = ext << unit;
endmodule

// File: rtl/dsc_seq_csum.sv
// Running checksum: wrapping sum of zero-extended transfer units.
module dsc_seq_csum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add,
    input  logic [1:0]  unit,
    input  logic [31:0] data,
    output logic [31:0] sum
);
    logic [31:0] lane;

    always_comb begin
        unique case (unit)
            2'd0:    lane = {24'h0, data[7:0]};
            2'd1:    lane = {16'h0, data[15:0]};
            default: lane = data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (add) sum <= sum + lane;
    end

    // a clear always leaves a zero sum
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == 32'h0));
endmodule

// File: rtl/dsc_chain_seq.sv
module dsc_chain_seq
    import dsc_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int STEPW = 4,
    parameter int CW    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_start,
    input  logic [AW-1:0]           start_desc,
    input  logic [1:0]              unit_size,
    input  logic signed [STEPW-1:0] src_step,
    input  logic signed [STEPW-1:0] dst_step,
    input  logic                    cmd_pause,
    input  logic                    cmd_resume,
    input  logic                    cmd_continue,
    input  logic                    cmd_kill,
    input  logic                    init_req,
    output logic                    rd_en,
    output logic [AW-1:0]           rd_addr,
    output logic [1:0]              rd_size,
    input  logic [31:0]             rd_data,
    output logic                    wr_en,
    output logic [AW-1:0]           wr_addr,
    output logic [1:0]              wr_size,
    output logic [31:0]             wr_data,
    output logic [2:0]              status,
    output logic                    irq,
    output logic [AW-1:0]           prog_src,
    output logic [AW-1:0]           prog_dst,
    output logic [CW-1:0]           prog_count,
    output logic [AW-1:0]           prog_desc
);
    localparam int MW = CW + 1;  // one spare bit so the moved counter cannot wrap

    seq_state_e              state;
    logic [2:0]              idx;
    logic                    paused, irq_q;
    logic [AW-1:0]           desc, src, dst, lastdst, nxt;
    logic [31:0]             flags, csum;
    logic [CW-1:0]           count;
    logic [MW-1:0]           moved, ub;
    logic [1:0]              su;
    logic signed [STEPW-1:0] sstep, dstep;
    logic [AW-1:0]           sofs, dofs;
    logic                    idle, start_ok, go, xfer_done, csum_clr;

    assign idle      = (state == ST_OFF) || (state == ST_DONE) || (state == ST_KILLED);
    assign start_ok  = idle && cmd_start;
    assign ub        = MW'(1) << su;
    assign go        = (state == ST_XFER) && !paused && init_req && !cmd_kill
                       && (moved < MW'(count));
    assign xfer_done = (state == ST_XFER) && !paused && (moved >= MW'(count));
    assign csum_clr  = start_ok || ((state == ST_FETCH) && (idx == W_NEXT) && flags[FL_RESTART]);

    dsc_seq_step #(.AW(AW), .STEPW(STEPW)) u_src_step (.unit(su), .step(sstep), .ofs(sofs));
    dsc_seq_step #(.AW(AW), .STEPW(STEPW)) u_dst_step (.unit(su), .step(dstep), .ofs(dofs));

    dsc_seq_csum u_csum (
        .clk(clk), .rst_n(rst_n), .clr(csum_clr), .add(go),
        .unit(su), .data(rd_data), .sum(csum)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            idx     <= '0;
            paused  <= 1'b0;
            irq_q   <= 1'b0;
            desc    <= '0;
            src     <= '0;
            dst     <= '0;
            lastdst <= '0;
            nxt     <= '0;
            flags   <= '0;
            count   <= '0;
            moved   <= '0;
            su      <= '0;
            sstep   <= '0;
            dstep   <= '0;
        end else begin
            irq_q <= 1'b0;
            if (!idle && cmd_kill) begin
                state  <= ST_KILLED;
                paused <= 1'b0;
            end else begin
                unique case (state)
                    ST_OFF, ST_DONE, ST_KILLED: begin
                        if (cmd_start) begin
                            desc   <= start_desc;
                            su     <= (unit_size == 2'd3) ? 2'd2 : unit_size;
                            sstep  <= src_step;
                            dstep  <= dst_step;
                            idx    <= '0;
                            paused <= 1'b0;
                            state  <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        case (idx)
                            W_FLAGS: flags <= rd_data;
                            W_SRC:   src   <= rd_data[AW-1:0];
                            W_DST: begin
                                dst     <= rd_data[AW-1:0];
                                lastdst <= rd_data[AW-1:0];
                            end
                            W_COUNT: begin
                                count <= rd_data[CW-1:0];
                                moved <= '0;
                            end
                            W_NEXT:  nxt <= rd_data[AW-1:0];
                            default: ;
                        endcase
                        if ((idx == W_FLAGS) && !rd_data[FL_OWN]) begin
                            state <= ST_PARK;
                        end else if (idx == W_NEXT) begin
                            state <= ST_XFER;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 3'd1;
                        end
                    end
                    ST_PARK: begin
                        if (cmd_continue) begin
                            state <= ST_FETCH;
                            idx   <= '0;
                        end
                    end
                    ST_XFER: begin
                        if (cmd_pause && !paused && !xfer_done) paused <= 1'b1;
                        else if (cmd_resume && paused)          paused <= 1'b0;
                        if (go) begin
                            src     <= src + sofs;
                            dst     <= dst + dofs;
                            lastdst <= dst;
                            moved   <= moved + ub;
                        end else if (xfer_done) begin
                            state <= ST_WBACK;
                            idx   <= '0;
                        end
                    end
                    ST_WBACK: begin
                        if (idx == 3'd2) begin
                            irq_q <= flags[FL_IRQ];
                            if (nxt == '0) begin
                                state <= ST_DONE;
                            end else begin
                                desc  <= nxt;
                                idx   <= '0;
                                state <= ST_FETCH;
                            end
                        end else begin
                            idx <= idx + 3'd1;
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = src;
        rd_size = su;
        wr_en   = go;
        wr_addr = dst;
        wr_size = su;
        wr_data = rd_data;
        status  = STS_WAIT;
        unique case (state)
            ST_OFF:    status = STS_NONE;
            ST_DONE:   status = STS_DONE;
            ST_KILLED: status = STS_KILL;
            ST_FETCH: begin
                rd_en   = 1'b1;
                rd_addr = desc + AW'({idx, 2'b00});
                rd_size = 2'd2;
            end
            ST_PARK: ;
            ST_XFER: begin
                rd_en  = go;
                status = paused ? STS_PAUSE : (init_req ? STS_RUN : STS_WAIT);
            end
            ST_WBACK: begin
                wr_en   = !cmd_kill;
                wr_size = 2'd2;
                case (idx)
                    3'd0: begin
                        wr_addr = desc + AW'(4 * W_FLAGS);
                        wr_data = flags & ~(32'h1 << FL_OWN);
                    end
                    3'd1: begin
                        wr_addr = desc + AW'(4 * W_CSUM);
                        wr_data = csum;
                    end
                    default: begin
                        wr_addr = desc + AW'(4 * W_LAST);
                        wr_data = 32'(lastdst);
                    end
                endcase
            end
            default: ;
        endcase
    end

    assign irq        = irq_q;
    assign prog_src   = src;
    assign prog_dst   = dst;
    assign prog_count = moved[CW-1:0];
    assign prog_desc  = desc;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STS_NONE) |-> (!rd_en && !wr_en));

    assert_info_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK && wr_en) |-> (wr_addr != desc + AW'(4 * W_INFO)));

    assert_park_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK) |-> !wr_en);

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_pause_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STS_PAUSE) |=> ($stable(prog_src) && $stable(prog_dst)));

    assert_kill_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STS_KILL && !cmd_start) |=> (status == STS_KILL));
endmodule

// File: tb/sim_dsc_chain_seq.sv
module sim_dsc_chain_seq;
    localparam int AW = 12;
    localparam int STEPW = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, cmd_pause = 0, cmd_resume = 0, cmd_continue = 0, cmd_kill = 0;
    logic [AW-1:0] start_desc = '0;
    logic [1:0] unit_size = '0;
    logic signed [STEPW-1:0] src_step = '0, dst_step = '0;
    logic init_req = 1'b1;
    logic rd_en, wr_en, irq;
    logic [AW-1:0] rd_addr, wr_addr, prog_src, prog_dst, prog_desc;
    logic [1:0] rd_size, wr_size;
    logic [31:0] rd_data, wr_data;
    logic [2:0] status;
    logic [CW-1:0] prog_count;

    logic [7:0] mem [0:4095];
    logic [7:0] exp_mem [0:4095];
    logic tb_we = 1'b0;
    logic [11:0] tb_wa = '0;
    logic [31:0] tb_wd = '0;
    int wr_cnt = 0;
    int irq_cnt = 0;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dsc_chain_seq #(.AW(AW), .STEPW(STEPW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_desc(start_desc),
        .unit_size(unit_size), .src_step(src_step), .dst_step(dst_step),
        .cmd_pause(cmd_pause), .cmd_resume(cmd_resume), .cmd_continue(cmd_continue),
        .cmd_kill(cmd_kill), .init_req(init_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .status(status), .irq(irq), .prog_src(prog_src), .prog_dst(prog_dst),
        .prog_count(prog_count), .prog_desc(prog_desc)
    );

    assign rd_data = {mem[rd_addr + 12'd3], mem[rd_addr + 12'd2],
                      mem[rd_addr + 12'd1], mem[rd_addr]};

    // memory model: engine writes and bench set-up writes
    always @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < 4; i++)
                if (i < (1 << wr_size)) mem[wr_addr + 12'(i)] <= wr_data[8*i +: 8];
            wr_cnt <= wr_cnt + 1;
        end
        if (tb_we)
            for (int i = 0; i < 4; i++) mem[tb_wa + 12'(i)] <= tb_wd[8*i +: 8];
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic poke32(input logic [11:0] a, input logic [31:0] v);
        tb_we = 1'b1; tb_wa = a; tb_wd = v;
        for (int i = 0; i < 4; i++) exp_mem[a + 12'(i)] = v[8*i +: 8];
        @(posedge clk);
        #1 tb_we = 1'b0;
    endtask

    function automatic logic [31:0] peek32(input logic [11:0] a);
        return {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
    endfunction

    function automatic logic [31:0] ex_rd(input logic [11:0] a, input int sz);
        logic [31:0] v = {exp_mem[a + 12'd3], exp_mem[a + 12'd2], exp_mem[a + 12'd1], exp_mem[a]};
        if (sz == 0) v = v & 32'hFF;
        else if (sz == 1) v = v & 32'hFFFF;
        return v;
    endfunction

    task automatic ex_wr(input logic [11:0] a, input logic [31:0] v, input int sz);
        for (int i = 0; i < (1 << sz); i++) exp_mem[a + 12'(i)] = v[8*i +: 8];
    endtask

    task automatic sync_exp();
        for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];
    endtask

    task automatic put_desc(input logic [11:0] a, input logic [31:0] fl, input logic [11:0] s,
                            input logic [11:0] t, input int cnt, input logic [11:0] nx,
                            input logic [31:0] info);
        poke32(a, fl);
        poke32(a + 12'd4, 32'h0);
        poke32(a + 12'd8, {20'h0, s});
        poke32(a + 12'd12, {20'h0, t});
        poke32(a + 12'd16, 32'h0);
        poke32(a + 12'd20, 32'(cnt));
        poke32(a + 12'd24, {20'h0, nx});
        poke32(a + 12'd28, info);
    endtask

    // reference walk of a chain over the expected image
    task automatic ref_run(input logic [11:0] d0, input int sz, input int ss, input int ds,
                           output int nirq, output logic [11:0] dlast, output int mlast);
        logic [11:0] d = d0;
        logic [31:0] ck = 0;
        nirq = 0; dlast = d0; mlast = 0;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] fl, w;
            logic [11:0] s, t, last, nx;
            int cnt, mv, u;
            fl = ex_rd(d, 2);
            if (!fl[31]) break;
            if (fl[30]) ck = 0;
            w = ex_rd(d + 12'd8, 2);  s = w[11:0];
            w = ex_rd(d + 12'd12, 2); t = w[11:0];
            w = ex_rd(d + 12'd20, 2); cnt = int'(w[15:0]);
            w = ex_rd(d + 12'd24, 2); nx = w[11:0];
            u = 1 << sz; mv = 0; last = t;
            while (mv < cnt) begin
                w = ex_rd(s, sz);
                ck = ck + w;
                ex_wr(t, w, sz);
                last = t;
                s = s + 12'(ss * u);
                t = t + 12'(ds * u);
                mv = mv + u;
            end
            ex_wr(d, fl & 32'h7FFF_FFFF, 2);
            ex_wr(d + 12'd4, ck, 2);
            ex_wr(d + 12'd16, {20'h0, last}, 2);
            if (fl[28]) nirq++;
            dlast = d; mlast = mv;
            if (nx == 12'h0) break;
            d = nx;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int i = 12'h100; i < 4096; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, "memory image bytes differing", bad, 0);
    endtask

    task automatic do_cmd(input int which);
        case (which)
            0: cmd_start = 1'b1;
            1: cmd_pause = 1'b1;
            2: cmd_resume = 1'b1;
            3: cmd_continue = 1'b1;
            default: cmd_kill = 1'b1;
        endcase
        @(posedge clk);
        #1;
        cmd_start = 0; cmd_pause = 0; cmd_resume = 0; cmd_continue = 0; cmd_kill = 0;
    endtask

    task automatic launch(input logic [11:0] d, input int sz, input int ss, input int ds);
        start_desc = d; unit_size = 2'(sz);
        src_step = STEPW'(ss); dst_step = STEPW'(ds);
        do_cmd(0);
    endtask

    task automatic run_until(input logic [2:0] want, input int limit, input bit rnd);
        int n = 0;
        while (status != want && n < limit) begin
            if (rnd) init_req = (($urandom % 4) != 0);
            @(posedge clk);
            #1;
            n++;
        end
        init_req = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        int seed, nirq, mlast, i0, p, ps;
        logic [11:0] dlast;
        seed = $urandom(32'd2024);
        for (int a = 12'h100; a < 4096; a += 4) poke32(12'(a), $urandom);
        tick(2);
        rst_n = 1'b1;
        tick(2);

        // reset state
        chk(status == 3'd1, "R1", "status after reset", status, 1);
        chk(!rd_en && !wr_en, "R1", "requests after reset", {rd_en, wr_en}, 0);

        // parked descriptor, pause ignored, then continue
        put_desc(12'h200, 32'h0, 12'h600, 12'hE00, 8, 12'h0, 32'hA5A5_1234);
        i0 = wr_cnt;
        launch(12'h200, 2, 1, 1);
        tick(8);
        chk(status == 3'd2, "R4", "status while parked", status, 2);
        chk(wr_cnt == i0, "R4", "writes while parked", wr_cnt - i0, 0);
        do_cmd(1);
        tick(2);
        chk(status == 3'd2, "R11", "pause outside transfer ignored", status, 2);
        poke32(12'h200, 32'h9000_0000);
        i0 = irq_cnt;
        ref_run(12'h200, 2, 1, 1, nirq, dlast, mlast);
        do_cmd(3);
        run_until(3'd6, 200, 1'b0);
        tick(1);
        chk(status == 3'd6, "R10", "status after continue", status, 6);
        cmp_mem("R4");
        chk(irq_cnt - i0 == 1, "R9", "interrupt pulses", irq_cnt - i0, 1);
        chk(peek32(12'h21C) == 32'hA5A5_1234, "R3", "info word", peek32(12'h21C), 32'hA5A5_1234);

        // initiator gating, pause, resume, start while active, kill
        put_desc(12'h300, 32'h8000_0000, 12'h400, 12'hA00, 200, 12'h0, 32'h0);
        init_req = 1'b0;
        launch(12'h300, 0, 1, 2);
        tick(15);
        chk(status == 3'd2, "R2", "status with init_req low", status, 2);
        chk(prog_count == 0, "R2", "bytes moved with init_req low", prog_count, 0);
        init_req = 1'b1;
        tick(3);
        chk(status == 3'd3, "R2", "status with init_req high", status, 3);
        tick(20);
        do_cmd(1);
        chk(status == 3'd4, "R11", "status after pause", status, 4);
        p = prog_count; ps = prog_src;
        chk(prog_src == 12'h400 + 12'(p), "R13", "source progress", prog_src, 12'h400 + p);
        chk(prog_dst == 12'hA00 + 12'(2 * p), "R6", "destination progress", prog_dst, 12'hA00 + 2 * p);
        chk(prog_desc == 12'h300, "R13", "descriptor progress", prog_desc, 12'h300);
        tick(5);
        chk(prog_count == p && prog_src == ps, "R11", "frozen count while paused", prog_count, p);
        launch(12'h100, 0, 1, 1);
        chk(prog_desc == 12'h300 && status == 3'd4, "R14", "start while active", prog_desc, 12'h300);
        do_cmd(2);
        tick(3);
        chk(status == 3'd3 && prog_count > p, "R11", "count after resume", prog_count, p + 3);
        do_cmd(4);
        chk(status == 3'd5, "R12", "status after kill", status, 5);
        p = prog_count;
        do_cmd(2);
        do_cmd(3);
        tick(3);
        chk(status == 3'd5 && prog_count == p, "R12", "resume and continue after kill", status, 5);
        sync_exp();

        // zero byte count
        put_desc(12'h340, 32'h8000_0000, 12'h500, 12'hC00, 0, 12'h0, 32'h0);
        ref_run(12'h340, 2, 1, 1, nirq, dlast, mlast);
        launch(12'h340, 2, 1, 1);
        run_until(3'd6, 60, 1'b0);
        tick(1);
        chk(status == 3'd6, "R10", "status after empty descriptor", status, 6);
        chk(prog_count == 0, "R5", "bytes moved for zero count", prog_count, 0);
        chk(peek32(12'h350) == 32'hC00, "R8", "last destination for zero count", peek32(12'h350), 32'hC00);
        chk(peek32(12'h340) == 32'h0, "R8", "owned flag cleared", peek32(12'h340), 0);
        cmp_mem("R5");

        // random chains
        for (int it = 0; it < 6; it++) begin
            int nd, sz, ss, ds, e_irq, e_cnt;
            logic [11:0] e_desc;
            nd = 1 + ($urandom % 3);
            sz = $urandom % 3;
            ss = int'($urandom % 4) - 1;
            ds = int'($urandom % 4) - 1;
            for (int k = 0; k < nd; k++) begin
                logic [31:0] fl;
                fl = 32'h8000_0000 | (($urandom % 2) << 30) | (($urandom % 2) << 28);
                put_desc(12'h100 + 12'(k * 64), fl, 12'h400 + 12'($urandom % 512),
                         12'hA80 + 12'($urandom % 768), $urandom % 25,
                         (k == nd - 1) ? 12'h0 : 12'h100 + 12'((k + 1) * 64), $urandom);
            end
            ref_run(12'h100, sz, ss, ds, e_irq, e_desc, e_cnt);
            i0 = irq_cnt;
            launch(12'h100, sz, ss, ds);
            run_until(3'd6, 2000, 1'b1);
            tick(1);
            chk(status == 3'd6, "R10", "random chain completion", status, 6);
            cmp_mem("R5 R6 R8");
            chk(peek32(e_desc + 12'd4) == ex_rd(e_desc + 12'd4, 2), "R7", "checksum word",
                peek32(e_desc + 12'd4), ex_rd(e_desc + 12'd4, 2));
            chk(irq_cnt - i0 == e_irq, "R9", "random interrupt count", irq_cnt - i0, e_irq);
            chk(prog_desc == e_desc, "R13", "final descriptor", prog_desc, e_desc);
            chk(prog_count == e_cnt, "R13", "final byte count", prog_count, e_cnt);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule